// File: doc/BRIEF.md
# Clock Reference Mode Controller

This block supervises a digital phase-locked loop. It chooses which of four reference clocks the loop follows, and it sets the timing mode the loop runs in. A set of per-reference health flags comes from external monitors. Software programs the mode, an optional forced reference and an optional preferred reference through a small register port. From these the block drives three mutually exclusive controls to the loop core: track, holdover-freeze and freerun. It also drives the selected reference index and a pulse on every change of that index.

In automatic mode the controller handles failover by itself. When the reference in use loses its valid flag, the loop is frozen in holdover. Once any reference is valid again, the controller moves to a new one, taking the preferred reference when possible. A valid preferred reference is also re-taken whenever it is not the one in use. A status register shows the loop controls, the selected index, the lock input, a sticky switch flag and the automatic-holdover state.

Top module: `clkref_mode_ctrl`

## Requirements
- R1: After reset the mode is freerun (code 2), the selected index is 0, only the freerun control is high, the switch pulse is low, and all software fields are cleared.
- R2: Register 0 bits [2:0] set the mode: 0 normal, 1 holdover, 2 freerun, 3 automatic, 4 internal reset. A write shows on mode_o one cycle later. A write of code 5, 6 or 7 leaves the mode unchanged.
- R3: Track is high in normal mode, and in automatic mode outside automatic holdover. Holdover-freeze is high in holdover mode and in automatic holdover. Freerun is high only in freerun mode. At most one of the three is high at any time.
- R4: In automatic mode with no force, loss of the valid flag of the selected reference causes automatic holdover on the next cycle, and the index is kept. On the first later cycle with any valid reference, the index becomes the preferred reference if that one is enabled and valid, and otherwise the lowest-indexed valid reference. With no valid reference the block stays in holdover.
- R5: Register 2 holds the preferred reference in bits [1:0] and its enable in bit 2. In automatic mode outside holdover, an enabled and valid preferred reference that is not selected becomes the selected index on the next cycle.
- R6: Register 1 holds the forced reference in bits [1:0] and its enable in bit 2. In normal or automatic mode with force enabled, the index becomes the forced reference on the next cycle and stays there whatever the valid flags show. Automatic holdover is not entered while force is enabled.
- R7: In holdover and freerun modes the selected index does not change, whatever the valid flags, force and preference settings are.
- R8: In internal-reset mode all three loop controls are low, and the index becomes 0 on the next cycle.
- R9: switch_evt_o is high for exactly the cycles in which ref_sel_o shows a value that differs from its value in the previous cycle.
- R10: Register 3 reads back the following fields: bit 0 track, bit 1 holdover-freeze, bit 2 freerun, bits [4:3] index, bit 5 lock input, bit 6 sticky switch flag, bit 7 automatic holdover. The sticky flag is set by every switch and cleared by writing 1 to bit 6. A switch in the same cycle as the clear wins.
- R11: Registers 0 to 2 read back their stored fields in their low bits, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_ok_i | input | 4 | Per-reference valid flag, 1 = usable |
| lock_i | input | 1 | Lock indication from the loop |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| mode_o | output | 3 | Current mode code |
| ref_sel_o | output | 2 | Selected reference index |
| track_en_o | output | 1 | Loop follows the selected reference |
| hold_freeze_o | output | 1 | Loop frequency frozen |
| freerun_en_o | output | 1 | Loop runs from its local oscillator |
| switch_evt_o | output | 1 | One-cycle pulse on each reference change |

## Verification
Automatic failover is driven with several valid-flag patterns. A single loss with higher references still valid shows the lowest-valid pick. A loss of every reference shows that holdover is held and that the index does not drift. A loss while the preferred reference is valid tells the preferred-first rule apart from the lowest-index rule. Reverting to a preferred reference that comes back, forcing with all flags cleared, and the same flag patterns applied in normal, holdover and freerun modes separate the policies of the modes. Internal reset, an unused mode code, and a sticky-flag clear followed by a readback cover the remaining corners.

// File: rtl/clkref_pkg.sv
package clkref_pkg;
    typedef enum logic [2:0] {
        MD_NORMAL = 3'd0,
        MD_HOLD   = 3'd1,
        MD_FREE   = 3'd2,
        MD_AUTO   = 3'd3,
        MD_IRST   = 3'd4
    } mode_e;

    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_MODE  = 2'd0;
    localparam logic [ADDR_W-1:0] A_FORCE = 2'd1;
    localparam logic [ADDR_W-1:0] A_PREF  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;
endpackage

// File: rtl/clkref_lowest_pick.sv
module clkref_lowest_pick #(
    parameter int unsigned N_REF = 4,
    localparam int unsigned REF_W = $clog2(N_REF)
) (
    input  logic [N_REF-1:0] ok_i,
    output logic [REF_W-1:0] idx_o,
    output logic             any_o
);
    logic [N_REF:0]   seen;
    logic [N_REF-1:0] first;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < N_REF; g++) begin : g_chain
        assign seen[g+1] = seen[g] | ok_i[g];
        assign first[g]  = ok_i[g] & ~seen[g];
    end

    assign any_o = seen[N_REF];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N_REF; i++) begin
            if (first[i]) idx_o = idx_o | REF_W'(i);
        end
    end
endmodule

// File: rtl/clkref_cfg_regs.sv
module clkref_cfg_regs
    import clkref_pkg::*;
#(
    parameter int unsigned N_REF  = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STICKY_BIT = 6,
    localparam int unsigned REF_W = $clog2(N_REF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              switch_nxt_i,
    output mode_e             mode_o,
    output logic              force_en_o,
    output logic [REF_W-1:0]  force_ref_o,
    output logic              pref_en_o,
    output logic [REF_W-1:0]  pref_ref_o,
    output logic              sticky_o
);
    typedef struct packed {
        mode_e            mode;
        logic             force_en;
        logic [REF_W-1:0] force_ref;
        logic             pref_en;
        logic [REF_W-1:0] pref_ref;
        logic             sticky;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic clr_req;

    always_comb begin
        cfg_d   = cfg_q;
        clr_req = 1'b0;
        if (we_i) begin
            unique case (addr_i)
                A_MODE: begin
                    case (wdata_i[2:0])
                        3'd0, 3'd1, 3'd2, 3'd3, 3'd4: cfg_d.mode = mode_e'(wdata_i[2:0]);
                        default: ;
                    endcase
                end
                A_FORCE: begin
                    cfg_d.force_ref = wdata_i[REF_W-1:0];
                    cfg_d.force_en  = wdata_i[REF_W];
                end
                A_PREF: begin
                    cfg_d.pref_ref = wdata_i[REF_W-1:0];
                    cfg_d.pref_en  = wdata_i[REF_W];
                end
                A_STAT: clr_req = wdata_i[STICKY_BIT];
                default: ;
            endcase
        end
        cfg_d.sticky = (cfg_q.sticky & ~clr_req) | switch_nxt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MD_FREE, force_en: 1'b0, force_ref: '0,
                       pref_en: 1'b0, pref_ref: '0, sticky: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o      = cfg_q.mode;
    assign force_en_o  = cfg_q.force_en;
    assign force_ref_o = cfg_q.force_ref;
    assign pref_en_o   = cfg_q.pref_en;
    assign pref_ref_o  = cfg_q.pref_ref;
    assign sticky_o    = cfg_q.sticky;
endmodule

// File: rtl/clkref_sel_fsm.sv
module clkref_sel_fsm
    import clkref_pkg::*;
#(
    parameter int unsigned N_REF = 4,
    localparam int unsigned REF_W = $clog2(N_REF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode_i,
    input  logic [N_REF-1:0] ref_ok_i,
    input  logic             force_en_i,
    input  logic [REF_W-1:0] force_ref_i,
    input  logic             pref_en_i,
    input  logic [REF_W-1:0] pref_ref_i,
    input  logic [REF_W-1:0] pick_idx_i,
    input  logic             pick_any_i,
    output logic [REF_W-1:0] sel_o,
    output logic             ahold_o,
    output logic             evt_o,
    output logic             switch_nxt_o
);
    typedef struct packed {
        logic [REF_W-1:0] sel;
        logic             ahold;
        logic             evt;
    } sel_t;

    sel_t st_d, st_q;
    logic pref_usable;

    assign pref_usable = pref_en_i & ref_ok_i[pref_ref_i];

    always_comb begin
        st_d       = st_q;
        st_d.ahold = 1'b0;
        unique case (mode_i)
            MD_IRST: st_d.sel = '0;
            MD_NORMAL: begin
                if (force_en_i) st_d.sel = force_ref_i;
            end
            MD_AUTO: begin
                if (force_en_i) begin
                    st_d.sel = force_ref_i;
                end else if (st_q.ahold) begin
                    if (pick_any_i) begin
                        st_d.sel = pref_usable ? pref_ref_i : pick_idx_i;
                    end else begin
                        st_d.ahold = 1'b1;
                    end
                end else if (!ref_ok_i[st_q.sel]) begin
                    st_d.ahold = 1'b1;
                end else if (pref_usable) begin
                    st_d.sel = pref_ref_i;
                end
            end
            default: ;
        endcase
        st_d.evt = (st_d.sel != st_q.sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o        = st_q.sel;
    assign ahold_o      = st_q.ahold;
    assign evt_o        = st_q.evt;
    assign switch_nxt_o = st_d.evt;
endmodule

// File: rtl/clkref_mode_ctrl.sv
module clkref_mode_ctrl
    import clkref_pkg::*;
#(
    parameter int unsigned N_REF  = 4,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned REF_W = $clog2(N_REF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REF-1:0]  ref_ok_i,
    input  logic              lock_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [2:0]        mode_o,
    output logic [REF_W-1:0]  ref_sel_o,
    output logic              track_en_o,
    output logic              hold_freeze_o,
    output logic              freerun_en_o,
    output logic              switch_evt_o
);
    localparam int unsigned ST_SEL_LO = 3;
    localparam int unsigned ST_LOCK   = ST_SEL_LO + REF_W;
    localparam int unsigned ST_STICKY = ST_LOCK + 1;
    localparam int unsigned ST_AHOLD  = ST_STICKY + 1;

    mode_e            mode;
    logic             force_en, pref_en, sticky, ahold, switch_nxt;
    logic [REF_W-1:0] force_ref, pref_ref, pick_idx, sel;
    logic             pick_any;

    clkref_cfg_regs #(.N_REF(N_REF), .DATA_W(DATA_W), .STICKY_BIT(ST_STICKY)) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (reg_we_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .switch_nxt_i(switch_nxt),
        .mode_o      (mode),
        .force_en_o  (force_en),
        .force_ref_o (force_ref),
        .pref_en_o   (pref_en),
        .pref_ref_o  (pref_ref),
        .sticky_o    (sticky)
    );

    clkref_lowest_pick #(.N_REF(N_REF)) i_pick (
        .ok_i (ref_ok_i),
        .idx_o(pick_idx),
        .any_o(pick_any)
    );

    clkref_sel_fsm #(.N_REF(N_REF)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .ref_ok_i    (ref_ok_i),
        .force_en_i  (force_en),
        .force_ref_i (force_ref),
        .pref_en_i   (pref_en),
        .pref_ref_i  (pref_ref),
        .pick_idx_i  (pick_idx),
        .pick_any_i  (pick_any),
        .sel_o       (sel),
        .ahold_o     (ahold),
        .evt_o       (switch_evt_o),
        .switch_nxt_o(switch_nxt)
    );

    assign mode_o        = mode;
    assign ref_sel_o     = sel;
    assign track_en_o    = (mode == MD_NORMAL) | ((mode == MD_AUTO) & ~ahold);
    assign hold_freeze_o = (mode == MD_HOLD) | ((mode == MD_AUTO) & ahold);
    assign freerun_en_o  = (mode == MD_FREE);

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_MODE:  reg_rdata_o[2:0] = mode;
            A_FORCE: reg_rdata_o[REF_W:0] = {force_en, force_ref};
            A_PREF:  reg_rdata_o[REF_W:0] = {pref_en, pref_ref};
            A_STAT: begin
                reg_rdata_o[0] = track_en_o;
                reg_rdata_o[1] = hold_freeze_o;
                reg_rdata_o[2] = freerun_en_o;
                reg_rdata_o[ST_SEL_LO +: REF_W] = sel;
                reg_rdata_o[ST_LOCK]   = lock_i;
                reg_rdata_o[ST_STICKY] = sticky;
                reg_rdata_o[ST_AHOLD]  = ahold;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/clkref_mode_ctrl_chk.sv
module clkref_mode_ctrl_chk #(
    parameter int unsigned N_REF  = 4,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned REF_W = $clog2(N_REF)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_REF-1:0]  ref_ok_i,
    input logic              reg_we_i,
    input logic [1:0]        reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [2:0]        mode_o,
    input logic [REF_W-1:0]  ref_sel_o,
    input logic              track_en_o,
    input logic              hold_freeze_o,
    input logic              freerun_en_o,
    input logic              switch_evt_o,
    input logic              force_en
);
    assert_one_control_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({track_en_o, hold_freeze_o, freerun_en_o}));

    assert_bad_code_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i[2:0] > 3'd4) |=> $stable(mode_o));

    assert_fail_enters_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && track_en_o && !force_en && !ref_ok_i[ref_sel_o] && !reg_we_i)
        |=> hold_freeze_o);

    assert_hold_free_keep_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1 || mode_o == 3'd2) |=> $stable(ref_sel_o));

    assert_irst_controls_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |-> !(track_en_o || hold_freeze_o || freerun_en_o));

    assert_irst_index_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |=> (ref_sel_o == '0));

    assert_pulse_means_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        switch_evt_o |-> (ref_sel_o != $past(ref_sel_o)));

    assert_quiet_means_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !switch_evt_o |-> $stable(ref_sel_o));
endmodule

bind clkref_mode_ctrl clkref_mode_ctrl_chk #(.N_REF(N_REF), .DATA_W(DATA_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_ok_i     (ref_ok_i),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .mode_o       (mode_o),
    .ref_sel_o    (ref_sel_o),
    .track_en_o   (track_en_o),
    .hold_freeze_o(hold_freeze_o),
    .freerun_en_o (freerun_en_o),
    .switch_evt_o (switch_evt_o),
    .force_en     (force_en)
);

// File: tb/test_clkref_mode_ctrl.sv
module test_clkref_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ref_ok = 4'b1111;
    logic       lock = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [2:0] mode;
    logic [1:0] ref_sel;
    logic       track_en, hold_freeze, freerun_en, switch_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    clkref_mode_ctrl i_clkref_mode_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_ok_i     (ref_ok),
        .lock_i       (lock),
        .reg_we_i     (reg_we),
        .reg_addr_i   (reg_addr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .mode_o       (mode),
        .ref_sel_o    (ref_sel),
        .track_en_o   (track_en),
        .hold_freeze_o(hold_freeze),
        .freerun_en_o (freerun_en),
        .switch_evt_o (switch_evt)
    );

    typedef struct {
        string       tag;
        logic [19:0] exp;
        logic [19:0] mask;
    } item_t;
    item_t sb[$];

    logic [19:0] obs;
    assign obs = {reg_rdata, 3'b000, switch_evt, mode, ref_sel, track_en, hold_freeze, freerun_en};

    task automatic exp_st(string tag, int md, int sl, bit t, bit h, bit f, bit e);
        item_t it;
        it.tag  = tag;
        it.exp  = {8'h00, 3'b000, e, md[2:0], sl[1:0], t, h, f};
        it.mask = 20'h001FF;
        sb.push_back(it);
    endtask

    task automatic exp_rd(string tag, int a, int v);
        item_t it;
        reg_addr = a[1:0];
        it.tag  = tag;
        it.exp  = {v[7:0], 12'h000};
        it.mask = 20'hFF000;
        sb.push_back(it);
    endtask

    task automatic wr(int a, int d);
        reg_we    = 1'b1;
        reg_addr  = a[1:0];
        reg_wdata = d[7:0];
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if ((obs & it.mask) != (it.exp & it.mask)) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", it.tag, obs & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        tick(3);
        rst_n = 1'b1;
        exp_st("R1 reset state", 2, 0, 0, 0, 1, 0);
        exp_rd("R1 R11 force reg cleared", 1, 0);
        tick(1);

        wr(0, 3);
        exp_st("R2 R3 automatic tracking", 3, 0, 1, 0, 0, 0);
        tick(1);
        exp_st("R3 auto steady", 3, 0, 1, 0, 0, 0);

        ref_ok = 4'b1110;
        tick(1);
        exp_st("R4 loss enters holdover", 3, 0, 0, 1, 0, 0);
        tick(1);
        exp_st("R4 R9 lowest valid taken", 3, 1, 1, 0, 0, 1);
        tick(1);
        exp_st("R9 pulse one cycle", 3, 1, 1, 0, 0, 0);
        exp_rd("R10 status after switch", 3, 8'h69);
        tick(1);
        wr(3, 8'h40);
        exp_rd("R10 sticky cleared", 3, 8'h29);
        tick(1);

        ref_ok = 4'b0000;
        tick(1);
        exp_st("R4 all lost holdover", 3, 1, 0, 1, 0, 0);
        tick(3);
        exp_st("R4 holdover kept", 3, 1, 0, 1, 0, 0);
        exp_rd("R10 auto holdover bit", 3, 8'hAA);
        ref_ok = 4'b0100;
        tick(1);
        exp_st("R4 recovery to ref2", 3, 2, 1, 0, 0, 1);

        wr(2, 8'h04);
        tick(1);
        exp_st("R5 invalid preferred not taken", 3, 2, 1, 0, 0, 0);
        exp_rd("R11 pref readback", 2, 8'h04);
        ref_ok = 4'b0101;
        tick(1);
        exp_st("R5 revert to preferred", 3, 0, 1, 0, 0, 1);

        wr(2, 8'h07);
        ref_ok = 4'b1010;
        tick(1);
        exp_st("R4 loss with preferred", 3, 0, 0, 1, 0, 0);
        tick(1);
        exp_st("R4 R5 preferred beats lowest", 3, 3, 1, 0, 0, 1);
        wr(2, 8'h00);

        wr(1, 8'h05);
        tick(1);
        exp_st("R6 forced in auto", 3, 1, 1, 0, 0, 1);
        ref_ok = 4'b0000;
        tick(2);
        exp_st("R6 force ignores flags", 3, 1, 1, 0, 0, 0);
        wr(1, 8'h00);
        ref_ok = 4'b1010;

        wr(0, 0);
        ref_ok = 4'b0000;
        tick(2);
        exp_st("R3 normal keeps tracking", 0, 1, 1, 0, 0, 0);
        wr(1, 8'h06);
        tick(1);
        exp_st("R6 forced in normal", 0, 2, 1, 0, 0, 1);

        wr(0, 1);
        wr(1, 8'h04);
        ref_ok = 4'b1111;
        tick(2);
        exp_st("R7 holdover keeps index", 1, 2, 0, 1, 0, 0);
        exp_rd("R11 force readback", 1, 8'h04);
        tick(1);

        wr(0, 2);
        tick(2);
        exp_st("R7 freerun keeps index", 2, 2, 0, 0, 1, 0);

        wr(0, 6);
        tick(1);
        exp_st("R2 unused code ignored", 2, 2, 0, 0, 1, 0);
        exp_rd("R11 mode readback", 0, 2);
        tick(1);

        wr(0, 4);
        exp_st("R8 internal reset controls low", 4, 2, 0, 0, 0, 0);
        tick(1);
        exp_st("R8 R9 index to zero", 4, 0, 0, 0, 0, 1);
        tick(1);
        exp_st("R8 held", 4, 0, 0, 0, 0, 0);
        exp_rd("R10 sticky set again", 3, 8'h60);
        tick(1);

        wr(0, 3);
        ref_ok = 4'b0000;
        tick(1);
        exp_st("R6 force active after release", 3, 0, 1, 0, 0, 0);

        tick(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule